// File: doc/BRIEF.md
# Zero-Substitution Line Decoder

This block sits in the recovered-clock domain of a primary-rate receiver. It takes retimed dual-rail line data, with one rail for positive marks and one for negative marks, and tracks the alternate-mark polarity of the stream. It recognises the zero-substitution code words of the 1.544 MHz rate (eight-bit word `000VB0VB`) and the 2.048 MHz rate (four-bit words `000V` and `B00V`). Here V is a mark with the same polarity as the mark before it, and B is a mark that obeys normal alternation.

When suppression is on, each recognised word for the selected rate is replaced by zeros on both output rails. When suppression is off, the data passes through unchanged. Every symbol passes through an eight-stage delay line, so a whole code word is seen before any of its bits leave the block. A bipolar-violation flag travels down the delay line with its symbol and stays aligned with the output bit that caused it.

Top module: `zero_sub_decoder`

## Requirements
- R1: Output rails reproduce the input rails with a latency of exactly DEPTH (default 8) clock cycles. A high on `posOut` is a positive mark, a high on `negOut` is a negative mark, and both low is a zero.
- R2: With `suppressEn` low, every single-rail symbol (including the marks of code words) appears on the output unaltered, for either value of `rateSel`.
- R3: With `suppressEn` high and `rateSel` low, a received `0 0 0 V B 0 V B` pattern leaves the block as eight zeros. V has the polarity of the mark before the word and B the opposite polarity.
- R4: With `suppressEn` high and `rateSel` high, a received `0 0 0 V` leaves the block as four zeros. In this mode `bpvOut` carries no defined meaning.
- R5: With `suppressEn` high and `rateSel` high, a received `B 0 0 V` leaves the block as four zeros. B alternates normally and V repeats B's polarity.
- R6: `bpvOut` is high for exactly the output bit period of a mark whose polarity equals that of the previous mark, and low for correctly alternating marks and zeros.
- R7: The first mark after reset is never flagged as a violation.
- R8: With `suppressEn` high and `rateSel` low, the two violations inside a suppressed eight-bit word are not flagged. Violations outside such a word are still flagged.
- R9: An input bit with both rails high is output as a zero with `bpvOut` high. It does not change the remembered polarity, and the output rails are never both high.
- R10: With `rateSel` low, a four-bit `000V` pattern is not a code word. It passes unchanged and its V is flagged, even when `suppressEn` is high.
- R11: While reset is asserted and right after it is released, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered line clock, one bit per cycle |
| rstN | input | 1 | Synchronous active-low reset |
| posIn | input | 1 | Positive-mark rail of the retimed line data |
| negIn | input | 1 | Negative-mark rail of the retimed line data |
| rateSel | input | 1 | 0 selects the eight-bit word, 1 selects the four-bit words |
| suppressEn | input | 1 | 1 replaces recognised code words with zeros |
| posOut | output | 1 | Delayed positive-mark rail |
| negOut | output | 1 | Delayed negative-mark rail |
| bpvOut | output | 1 | Violation flag aligned with the output bit |

## Verification
The bench aims at words whose V has either polarity, and at ordinary marks right after a word. A design that mistracked polarity through a cleared word would then flag a good mark or miss a real violation. It feeds the four-bit word in the eight-bit mode and the full words with suppression off. A design that ignored the rate or the enable would clear or keep the wrong bits, or lose the violation flags. Both-high inputs and the first mark after reset are also covered: a wrong design would emit both rails high, update the polarity from a corrupt bit, or flag a mark that has no predecessor.

// File: rtl/zsd_pkg.sv
package zsd_pkg;

  // One line symbol as it travels down the delay line.
  typedef struct packed {
    logic pos;
    logic neg;
    logic viol;
  } symT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic entryViol;  // symbol now entering breaks alternation
    logic clrB8;      // eight-bit word occupies the newest stages
    logic clrHdb;     // four-bit word occupies the newest stages
  } ctlStrobeT;

  localparam symT SYM_IDLE = '{pos: 1'b0, neg: 1'b0, viol: 1'b0};

  localparam int B8_SPAN  = 8;
  localparam int HDB_SPAN = 4;

endpackage

// File: rtl/zsd_datapath.sv
module zsd_datapath
  import zsd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 posIn,
  input  logic                 negIn,
  input  ctlStrobeT            strb,
  output symT [DEPTH-1:0]      window,
  output logic                 posOut,
  output logic                 negOut,
  output logic                 bpvOut
);

  symT [DEPTH-1:0] stageQ;
  symT             outQ;
  symT             entrySym;
  logic [DEPTH-1:0] killVec;

  // A both-high bit enters as a zero carrying the violation flag.
  assign entrySym.pos  = posIn & ~negIn;
  assign entrySym.neg  = negIn & ~posIn;
  assign entrySym.viol = strb.entryViol;

  // Per-stage clear enables: the newest stages hold a detected word.
  for (genvar k = 0; k < DEPTH; k++) begin : g_kill
    if (k < HDB_SPAN) begin : g_both
      assign killVec[k] = strb.clrB8 | strb.clrHdb;
    end else if (k < B8_SPAN) begin : g_b8
      assign killVec[k] = strb.clrB8;
    end else begin : g_none
      assign killVec[k] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageQ[0] <= SYM_IDLE;
    end else begin
      stageQ[0] <= entrySym;
    end
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageQ[k] <= SYM_IDLE;
      end else begin
        stageQ[k] <= killVec[k-1] ? SYM_IDLE : stageQ[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ <= SYM_IDLE;
    end else begin
      outQ <= killVec[DEPTH-1] ? SYM_IDLE : stageQ[DEPTH-1];
    end
  end

  assign window = stageQ;
  assign posOut = outQ.pos;
  assign negOut = outQ.neg;
  assign bpvOut = outQ.viol;

  AST_RAILS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(posOut && negOut)); // R9

  AST_B8_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clrB8) |-> (stageQ[1] == SYM_IDLE)); // R3

  AST_HDB_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clrHdb) |-> (stageQ[1] == SYM_IDLE)); // R4

  AST_PLAIN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    $past(!strb.clrB8 && !strb.clrHdb) |-> (stageQ[1] == $past(stageQ[0]))); // R2

endmodule

// File: rtl/zsd_ctrl.sv
module zsd_ctrl
  import zsd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            posIn,
  input  logic            negIn,
  input  logic            rateSel,
  input  logic            suppressEn,
  input  symT [DEPTH-1:0] window,
  output ctlStrobeT       strb
);

  logic lastNegQ;
  logic seenMarkQ;
  logic markIn;
  logic bothIn;
  logic b8Hit;
  logic hdbHit;

  function automatic logic isIdle(input symT s);
    return !s.pos && !s.neg && !s.viol;
  endfunction

  function automatic logic isMark(input symT s);
    return s.pos ^ s.neg;
  endfunction

  assign markIn = posIn ^ negIn;
  assign bothIn = posIn & negIn;

  // Polarity memory; both-high bits leave it untouched.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastNegQ  <= 1'b0;
      seenMarkQ <= 1'b0;
    end else if (markIn) begin
      lastNegQ  <= negIn;
      seenMarkQ <= 1'b1;
    end
  end

  // window[0] is the newest symbol, window[7] the oldest of an eight-bit word.
  assign b8Hit = isIdle(window[7]) && isIdle(window[6]) && isIdle(window[5])
              && isMark(window[4]) && window[4].viol
              && isMark(window[3]) && !window[3].viol
              && (window[3].neg != window[4].neg)
              && isIdle(window[2])
              && isMark(window[1]) && window[1].viol
              && (window[1].neg == window[3].neg)
              && isMark(window[0]) && (window[0].neg != window[1].neg);

  // Four-bit word: two zeros then a violating mark; the leading bit is
  // either a zero or the balancing mark, both of which are cleared.
  assign hdbHit = isIdle(window[2]) && isIdle(window[1])
               && isMark(window[0]) && window[0].viol;

  assign strb.entryViol = bothIn | (markIn && seenMarkQ && (negIn == lastNegQ));
  assign strb.clrB8     = suppressEn && !rateSel && b8Hit;
  assign strb.clrHdb    = suppressEn &&  rateSel && hdbHit;

  AST_POL_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    (posIn ^ negIn) |=> (seenMarkQ && (lastNegQ == $past(negIn)))); // R6

  AST_BOTH_KEEPS_POL: assert property (@(posedge clk) disable iff (!rstN)
    (posIn && negIn) |=> $stable(lastNegQ)); // R9

endmodule

// File: rtl/zero_sub_decoder.sv
module zero_sub_decoder
  import zsd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic posIn,
  input  logic negIn,
  input  logic rateSel,
  input  logic suppressEn,
  output logic posOut,
  output logic negOut,
  output logic bpvOut
);

  ctlStrobeT       strb;
  symT [DEPTH-1:0] window;

  zsd_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .posIn      (posIn),
    .negIn      (negIn),
    .rateSel    (rateSel),
    .suppressEn (suppressEn),
    .window     (window),
    .strb       (strb)
  );

  zsd_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .posIn  (posIn),
    .negIn  (negIn),
    .strb   (strb),
    .window (window),
    .posOut (posOut),
    .negOut (negOut),
    .bpvOut (bpvOut)
  );

endmodule

// File: tb/tb_zero_sub_decoder.sv
module tb_zero_sub_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 8;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic posIn = 1'b0;
  logic negIn = 1'b0;
  logic rateSel = 1'b0;
  logic suppressEn = 1'b0;
  logic posOut, negOut, bpvOut;

  int totalChecks = 0;
  int failChecks  = 0;
  int cycleCount  = 0;

  zero_sub_decoder #(.DEPTH(LAT)) dut (
    .clk(clk), .rstN(rstN), .posIn(posIn), .negIn(negIn),
    .rateSel(rateSel), .suppressEn(suppressEn),
    .posOut(posOut), .negOut(negOut), .bpvOut(bpvOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycleCount++;
      if (cycleCount > WATCHDOG) begin
        failChecks++;
        totalChecks++;
        $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycleCount, WATCHDOG);
        $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
        $finish;
      end
    end
  end

  task automatic applyReset();
    rstN  = 1'b0;
    posIn = 1'b0;
    negIn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic driveSym(input byte c);
    posIn = (c == "+") || (c == "X");
    negIn = (c == "-") || (c == "X");
  endtask

  task automatic checkSym(input string req, input int idx, input byte expC, input byte bpvC);
    logic [1:0] expRails;
    logic [1:0] actRails;
    expRails = (expC == "+") ? 2'b10 : (expC == "-") ? 2'b01 : 2'b00;
    actRails = {posOut, negOut};
    totalChecks++;
    if (actRails != expRails || (bpvC != "x" && bpvOut != (bpvC == "1"))) begin
      failChecks++;
      $display("FAIL %s bit %0d: actual rails=%b bpv=%b, expected rails=%b bpv=%s",
               req, idx, actRails, bpvOut, expRails, string'(bpvC));
    end
  endtask

  // Feeds a symbol string and compares the output LAT cycles later.
  task automatic runCase(input string req, input bit rate, input bit sup,
                         input string inS, input string expS, input string bpvS);
    int n;
    rateSel    = rate;
    suppressEn = sup;
    applyReset();
    n = inS.len();
    for (int j = 0; j < n + LAT; j++) begin
      driveSym((j < n) ? inS[j] : 8'h30);
      @(posedge clk);
      @(negedge clk);
      if (j >= LAT) checkSym(req, j - LAT, expS[j-LAT], bpvS[j-LAT]);
    end
    driveSym(8'h30);
  endtask

  task automatic testReset();
    rstN  = 1'b0;
    posIn = 1'b1;
    negIn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    totalChecks++;
    if ({posOut, negOut, bpvOut} != 3'b000) begin
      failChecks++;
      $display("FAIL R11 in reset: actual %b, expected 000", {posOut, negOut, bpvOut});
    end
    posIn = 1'b0;
    rstN  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    totalChecks++;
    if ({posOut, negOut, bpvOut} != 3'b000) begin
      failChecks++;
      $display("FAIL R11 after release: actual %b, expected 000", {posOut, negOut, bpvOut});
    end
  endtask

  task automatic testAmiClean();    // R1 R7
    runCase("R1", 1'b0, 1'b1, "+0-+-00+-", "+0-+-00+-", "000000000");
  endtask

  task automatic testFirstMark();   // R7
    runCase("R7", 1'b0, 1'b0, "0-0+", "0-0+", "0000");
  endtask

  task automatic testViolPlain();   // R6 R2
    runCase("R6", 1'b0, 1'b0, "+0+-0-", "+0+-0-", "001001");
  endtask

  task automatic testB8Suppress();  // R3 R8
    runCase("R3", 1'b0, 1'b1, "+000+-0-+-", "+00000000-", "0000000000");
  endtask

  task automatic testB8PassThrough(); // R2
    runCase("R2", 1'b0, 1'b0, "+000+-0-+-", "+000+-0-+-", "0000100100");
  endtask

  task automatic testB8NegThenViol(); // R8
    runCase("R8", 1'b0, 1'b1, "-000-+0+-+0+", "-00000000+0+", "000000000001");
  endtask

  task automatic testHdbZeros();    // R4
    runCase("R4", 1'b1, 1'b1, "+000+-", "+0000-", "0xxxx0");
  endtask

  task automatic testHdbBalanced(); // R5
    runCase("R5", 1'b1, 1'b1, "+-00-+", "+0000+", "0xxxx0");
  endtask

  task automatic testHdbPassThrough(); // R2
    runCase("R2", 1'b1, 1'b0, "+000+-", "+000+-", "000010");
  endtask

  task automatic testRateGating();  // R10
    runCase("R10", 1'b0, 1'b1, "+000+-", "+000+-", "000010");
  endtask

  task automatic testBothHigh();    // R9
    runCase("R9", 1'b0, 1'b0, "+X-+X+", "+0-+0+", "010011");
  endtask

  initial begin
    testReset();
    testAmiClean();
    testFirstMark();
    testViolPlain();
    testB8Suppress();
    testB8PassThrough();
    testB8NegThenViol();
    testHdbZeros();
    testHdbBalanced();
    testHdbPassThrough();
    testRateGating();
    testBothHigh();
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

endmodule